// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit linear address into a physical address by reading one 64-bit descriptor from each of four nested tables in memory. A request carries the linear address, an access kind and a privilege level. A separate input gives the register that holds the base of the top table. The walker first checks that the upper address bits are a proper sign extension. It then reads one descriptor per level through a single-outstanding memory port, and combines the permission bits it finds along the way.

When the walker reads a valid descriptor whose accessed flag is clear, it writes that descriptor back with the flag set before it goes down to the next level. The walk ends with a one-cycle completion pulse. The pulse carries either the physical address or a fault code. Only one walk is in flight at a time, and requests that arrive during a walk are dropped.

Top module: `xlat_walker`

## Requirements
- R1: A request is non-canonical when linear bits 63:47 are neither all zeros nor all ones. Such a request completes one cycle after acceptance with fault code 1, and no memory request is made.
- R2: The first descriptor is read at {base register bits 51:12, linear bits 47:39, 3'b000}. Each later descriptor is read at {bits 51:12 of the previous descriptor, index, 3'b000}. The index is linear bits 38:30, then 29:21, then 20:12.
- R3: A descriptor with bit 0 (valid) clear ends the walk with fault code 2, and no further memory request is made.
- R4: A valid descriptor with bit 5 (accessed) clear is written back to its own address with bit 5 set before the next read. A descriptor with bit 5 already set is not written.
- R5: When the privilege level is 3 (user), the walk faults with code 3 if bit 2 is clear in any of the four descriptors. Levels 0 to 2 are not restricted by bit 2.
- R6: A write access (kind 1) faults with code 3 if bit 1 is clear in any descriptor. A read (kind 0) is not restricted by bit 1.
- R7: A fetch access (kind 2) faults with code 3 if bit 63 is set in any descriptor. A read is not restricted by bit 63.
- R8: On success the fault code is 0, and the physical address is {bits 51:12 of the last descriptor, linear bits 11:0}. On any fault the physical address is 0. Base register bits 11:0 and descriptor bits 62:52, 11:6 and 4:3 have no effect.
- R9: The done output is high for exactly one cycle per accepted request. Busy is high from the cycle after acceptance until done rises, and is low while done is high. A request presented while busy is high is ignored.
- R10: Each memory request is a one-cycle pulse that is issued only while busy is high. The next request waits for the response to the previous one, so a successful walk makes exactly four reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 64 | Linear address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_priv | input | 2 | Privilege level, 3 is user |
| root_reg | input | 64 | Top table base register (bits 51:12 used) |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | 1 for descriptor write-back, 0 for read |
| mem_req_addr | output | 52 | Physical byte address of the descriptor |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Response strobe, one per request |
| mem_rsp_rdata | input | 64 | Read data |
| done | output | 1 | Completion pulse |
| fault | output | 2 | 0 none, 1 non-canonical, 2 not valid, 3 protection |
| phys_addr | output | 52 | Translated physical address |

## Verification
The assertions assume that the memory answers each request with exactly one response strobe and never sends one unprompted. They also assume that bits 63:52 of the base register are zero. The bench memory model follows this contract: it samples each request pulse once, answers after zero to two extra cycles, and keeps the base register's top bits clear. The randomly built tables use distinct frames at every level, so no descriptor is visited twice within a walk and the accessed-bit write-backs stay predictable.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int DESC_W       = 64;
  localparam int BIT_VALID    = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_NOEXEC   = 63;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NONCANON = 2'd1,
    FLT_ABSENT   = 2'd2,
    FLT_PROT     = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } access_e;

  typedef enum logic [1:0] {
    WS_IDLE      = 2'd0,
    WS_READ      = 2'd1,
    WS_WRITEBACK = 2'd2
  } walk_state_e;

  // Permissions gathered over the levels walked so far
  typedef struct packed {
    logic user_all;
    logic write_all;
    logic noexec_any;
  } perm_t;
endpackage

// File: rtl/xlat_vaddr_split.sv
module xlat_vaddr_split #(
  parameter int VA_W   = 48,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PAGE_W = 12
) (
  input  logic [63:0]                    vaddr,
  output logic                           canonical,
  output logic [LEVELS-1:0][IDX_W-1:0]   idx
);
  localparam int TOP_W = 64 - VA_W + 1;

  logic [TOP_W-1:0] top_bits;
  assign top_bits  = vaddr[63:VA_W-1];
  assign canonical = (top_bits == '0) || (top_bits == '1);

  // idx[0] selects within the last-level table, idx[LEVELS-1] within the root
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx[g] = vaddr[PAGE_W + g*IDX_W +: IDX_W];
  end

  logic unused_offset;
  assign unused_offset = ^vaddr[PAGE_W-1:0];
endmodule

// File: rtl/xlat_entry_decode.sv
module xlat_entry_decode #(
  parameter int PA_W   = 52,
  parameter int PAGE_W = 12
) (
  input  logic [63:0]             entry,
  output logic                    valid,
  output logic                    writable,
  output logic                    user_ok,
  output logic                    accessed,
  output logic                    noexec,
  output logic [PA_W-PAGE_W-1:0]  frame
);
  import xlat_pkg::*;

  assign valid    = entry[BIT_VALID];
  assign writable = entry[BIT_WRITABLE];
  assign user_ok  = entry[BIT_USER];
  assign accessed = entry[BIT_ACCESSED];
  assign noexec   = entry[BIT_NOEXEC];
  assign frame    = entry[PA_W-1:PAGE_W];

  logic unused_fields;
  assign unused_fields = ^{entry[62:PA_W], entry[PAGE_W-1:6], entry[4:3]};
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check (
  input  xlat_pkg::perm_t acc,
  input  logic            user_mode,
  input  logic [1:0]      kind,
  output logic            violation
);
  import xlat_pkg::*;

  logic user_bad, write_bad, fetch_bad;
  assign user_bad  = user_mode && !acc.user_all;
  assign write_bad = (kind == ACC_WRITE) && !acc.write_all;
  assign fetch_bad = (kind == ACC_FETCH) && acc.noexec_any;
  assign violation = user_bad || write_bad || fetch_bad;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PAGE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [63:0]      req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_priv,
  input  logic [63:0]      root_reg,
  output logic             busy,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [63:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_rdata,
  output logic             done,
  output logic [1:0]       fault,
  output logic [PA_W-1:0]  phys_addr
);
  import xlat_pkg::*;

  localparam int FRAME_W   = PA_W - PAGE_W;
  localparam int LVL_W     = $clog2(LEVELS);
  localparam int ENT_SHIFT = PAGE_W - IDX_W;   // log2 of descriptor bytes

  walk_state_e          state_q;
  logic [LVL_W-1:0]     lvl_q;
  logic [63:0]          vaddr_q;
  logic [1:0]           kind_q;
  logic                 user_q;
  logic [FRAME_W-1:0]   base_q;
  perm_t                acc_q;
  fault_e               fault_q;

  // Address split: the request while idle, the latched address during a walk
  logic [63:0]                  split_in;
  logic                         canonical;
  logic [LEVELS-1:0][IDX_W-1:0] idx_all;

  assign split_in = (state_q == WS_IDLE) ? req_vaddr : vaddr_q;

  xlat_vaddr_split #(
    .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .PAGE_W(PAGE_W)
  ) u_split (
    .vaddr(split_in), .canonical(canonical), .idx(idx_all)
  );

  logic               e_valid, e_writable, e_user, e_accessed, e_noexec;
  logic [FRAME_W-1:0] e_frame;

  xlat_entry_decode #(.PA_W(PA_W), .PAGE_W(PAGE_W)) u_decode (
    .entry(mem_rsp_rdata), .valid(e_valid), .writable(e_writable),
    .user_ok(e_user), .accessed(e_accessed), .noexec(e_noexec), .frame(e_frame)
  );

  logic rsp_read, rsp_wb;
  assign rsp_read = (state_q == WS_READ) && mem_rsp_valid;
  assign rsp_wb   = (state_q == WS_WRITEBACK) && mem_rsp_valid;

  // Permissions including the descriptor arriving this cycle
  perm_t acc_n;
  always_comb begin
    acc_n = acc_q;
    if (rsp_read) begin
      acc_n.user_all   = acc_q.user_all & e_user;
      acc_n.write_all  = acc_q.write_all & e_writable;
      acc_n.noexec_any = acc_q.noexec_any | e_noexec;
    end
  end

  logic violation;
  xlat_perm_check u_perm (
    .acc(acc_n), .user_mode(user_q), .kind(kind_q), .violation(violation)
  );

  // Step down a level: after a read whose accessed flag was set, or after write-back
  logic               advance;
  logic [FRAME_W-1:0] adv_base;
  logic [LVL_W-1:0]   lvl_dn;
  logic [IDX_W-1:0]   idx_next;
  assign advance  = (rsp_read && e_valid && e_accessed) || rsp_wb;
  assign adv_base = rsp_read ? e_frame : base_q;
  assign lvl_dn   = lvl_q - LVL_W'(1);
  assign idx_next = idx_all[lvl_dn];

  assign busy  = (state_q != WS_IDLE);
  assign fault = fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= WS_IDLE;
      lvl_q         <= '0;
      vaddr_q       <= '0;
      kind_q        <= '0;
      user_q        <= 1'b0;
      base_q        <= '0;
      acc_q         <= '0;
      fault_q       <= FLT_NONE;
      done          <= 1'b0;
      phys_addr     <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      done          <= 1'b0;
      case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            kind_q  <= req_kind;
            user_q  <= (req_priv == 2'd3);
            acc_q   <= '{user_all: 1'b1, write_all: 1'b1, noexec_any: 1'b0};
            if (!canonical) begin
              done      <= 1'b1;
              fault_q   <= FLT_NONCANON;
              phys_addr <= '0;
            end else begin
              state_q       <= WS_READ;
              lvl_q         <= LVL_W'(LEVELS - 1);
              mem_req_valid <= 1'b1;
              mem_req_write <= 1'b0;
              mem_req_addr  <= {root_reg[PA_W-1:PAGE_W], idx_all[LEVELS-1],
                                {ENT_SHIFT{1'b0}}};
            end
          end
        end
        WS_READ: begin
          if (mem_rsp_valid) begin
            if (!e_valid) begin
              state_q   <= WS_IDLE;
              done      <= 1'b1;
              fault_q   <= FLT_ABSENT;
              phys_addr <= '0;
            end else begin
              acc_q  <= acc_n;
              base_q <= e_frame;
              if (!e_accessed) begin
                // same address as the read just answered
                state_q       <= WS_WRITEBACK;
                mem_req_valid <= 1'b1;
                mem_req_write <= 1'b1;
                mem_req_wdata <= mem_rsp_rdata | (64'd1 << BIT_ACCESSED);
              end
            end
          end
        end
        default: ;
      endcase

      if (advance) begin
        if (lvl_q == '0) begin
          state_q   <= WS_IDLE;
          done      <= 1'b1;
          fault_q   <= violation ? FLT_PROT : FLT_NONE;
          phys_addr <= violation ? '0 : {adv_base, vaddr_q[PAGE_W-1:0]};
        end else begin
          state_q       <= WS_READ;
          lvl_q         <= lvl_dn;
          mem_req_valid <= 1'b1;
          mem_req_write <= 1'b0;
          mem_req_addr  <= {adv_base, idx_next, {ENT_SHIFT{1'b0}}};
        end
      end
    end
  end

  // R1: a badly sign-extended address completes on the next cycle with code 1
  assert_noncanon_done_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && !((&req_vaddr[63:VA_W-1]) || !(|req_vaddr[63:VA_W-1])))
    |=> (done && fault == FLT_NONCANON && !mem_req_valid));

  // R3: an invalid descriptor ends the walk at once
  assert_absent_stops_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == WS_READ && mem_rsp_valid && !mem_rsp_rdata[0])
    |=> (done && fault == FLT_ABSENT && !mem_req_valid));

  // R4: write-back always carries the accessed flag and the walk goes on
  assert_wb_accessed_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> (mem_req_wdata[BIT_ACCESSED] && busy));

  // R8: no address is reported with a fault
  assert_fault_zero_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (done && fault != FLT_NONE) |-> (phys_addr == '0));

  // R9: completion and busy never overlap
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: memory traffic only during a walk
  assert_mem_in_walk_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_priv = '0;
  logic [63:0] root_reg = '0;
  logic        busy;
  logic        mem_req_valid, mem_req_write;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic        done;
  logic [1:0]  fault;
  logic [51:0] phys_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_priv(req_priv), .root_reg(root_reg), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done(done), .fault(fault), .phys_addr(phys_addr)
  );

  int tests = 0;
  int fails = 0;
  logic [63:0] mem [logic [51:0]];
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [51:0] got_addr [16];
  logic [51:0] vis_addr [4];
  bit          vis_valid [4];
  int          vis_n = 0;

  function automatic logic [63:0] rd_mem(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: one response per request pulse, 0..2 extra cycles of delay
  initial begin
    logic [51:0] a;
    logic        w;
    int          lat;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid === 1'b1 && !rst) begin
        a = mem_req_addr;
        w = mem_req_write;
        lat = $urandom % 3;
        if (w) begin
          mem[a] = mem_req_wdata;
          wr_cnt++;
        end else begin
          got_addr[rd_cnt % 16] = a;
          rd_cnt++;
        end
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = w ? 64'd0 : rd_mem(a);
      end
    end
  end

  // Expected behaviour computed from the requirements
  task automatic ref_walk(input logic [63:0] va, input logic [1:0] kind,
                          input logic [1:0] prv, input logic [63:0] root,
                          output logic [1:0] f, output logic [51:0] pa,
                          output int nrd, output int nwr);
    logic [39:0] tbl;
    logic [63:0] e;
    logic [51:0] a;
    bit us, rw, nx;
    us = 1; rw = 1; nx = 0;
    f = 2'd0; pa = '0; nrd = 0; nwr = 0; vis_n = 0;
    if (!(va[63:47] == '0 || va[63:47] == '1)) begin
      f = 2'd1;
      return;
    end
    tbl = root[51:12];
    for (int lvl = 3; lvl >= 0; lvl--) begin
      a = {tbl, va[12 + 9*lvl +: 9], 3'b000};
      e = rd_mem(a);
      nrd++;
      vis_addr[vis_n] = a;
      vis_valid[vis_n] = e[0];
      vis_n++;
      if (!e[0]) begin
        f = 2'd2;
        return;
      end
      us = us & e[2];
      rw = rw & e[1];
      nx = nx | e[63];
      if (!e[5]) nwr++;
      tbl = e[51:12];
    end
    if ((prv == 2'd3 && !us) || (kind == 2'd1 && !rw) || (kind == 2'd2 && nx)) f = 2'd3;
    else pa = {tbl, va[11:0]};
  endtask

  // Four tables at consecutive frames after the root, final page frame last
  task automatic build_chain(input logic [63:0] root, input logic [63:0] va,
                             input logic [63:0] a3, input logic [63:0] a2,
                             input logic [63:0] a1, input logic [63:0] a0);
    logic [63:0] at [4];
    logic [39:0] tbl, nxt;
    at[3] = a3; at[2] = a2; at[1] = a1; at[0] = a0;
    mem.delete();
    tbl = root[51:12];
    for (int lvl = 3; lvl >= 0; lvl--) begin
      nxt = tbl + 40'd1;
      mem[{tbl, va[12 + 9*lvl +: 9], 3'b000}] =
        (at[lvl] & ~64'h000F_FFFF_FFFF_F000) | {12'b0, nxt, 12'b0};
      tbl = nxt;
    end
  endtask

  task automatic run_one(input logic [63:0] va, input logic [1:0] kind,
                         input logic [1:0] prv, input logic [63:0] root,
                         input bit poke);
    logic [1:0]  ef;
    logic [51:0] ep;
    int enr, enw, cyc;
    string tag;
    ref_walk(va, kind, prv, root, ef, ep, enr, enw);
    case (ef)
      2'd0: tag = "R8";
      2'd1: tag = "R1";
      2'd2: tag = "R3";
      default: tag = (kind == 2'd2) ? "R7" : (kind == 2'd1 && prv != 2'd3) ? "R6" : "R5";
    endcase
    rd_cnt = 0;
    wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_priv = prv; root_reg = root;
    @(negedge clk);
    req_valid = 1'b0;
    if (ef != 2'd1) chk(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 400) begin
      req_valid = poke && (cyc < 2);
      if (poke) req_vaddr = 64'h00F0_0000_0000_0000;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    if (cyc >= 400) begin
      chk(1'b0, "watchdog walk", 64'(cyc), 64'd0);
      return;
    end
    chk(fault === ef, {tag, " fault"}, 64'(fault), 64'(ef));
    chk(phys_addr === ep, {tag, " phys"}, 64'(phys_addr), 64'(ep));
    chk(busy === 1'b0, "R9 busy low at done", 64'(busy), 64'd0);
    chk(rd_cnt == enr, (ef == 2'd1) ? "R1 no access" : "R10 read count",
        64'(rd_cnt), 64'(enr));
    chk(wr_cnt == enw, "R4 write-back count", 64'(wr_cnt), 64'(enw));
    for (int k = 0; k < vis_n; k++) begin
      chk(got_addr[k] === vis_addr[k], "R2 descriptor address",
          64'(got_addr[k]), 64'(vis_addr[k]));
      if (vis_valid[k]) chk(rd_mem(vis_addr[k])[5] === 1'b1, "R4 accessed set",
                            rd_mem(vis_addr[k]), rd_mem(vis_addr[k]) | 64'h20);
    end
    @(negedge clk);
    chk(done === 1'b0, "R9 single pulse", 64'(done), 64'd0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9 busy request ignored", 64'(done), 64'd0);
      end
    end
  endtask

  function automatic logic [63:0] rand_attr();
    logic [63:0] r;
    r = {$urandom, $urandom} & 64'h7FF0_0000_0000_0FD8;
    r[0]  = ($urandom % 16) != 0;
    r[1]  = ($urandom % 4) != 0;
    r[2]  = ($urandom % 4) != 0;
    r[5]  = ($urandom % 2) != 0;
    r[63] = ($urandom % 4) == 0;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog global", 64'd0, 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] root, va;
    void'($urandom(32'h5EED_1234));
    root = 64'h0000_0001_2345_6ABC;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(busy === 1'b0 && done === 1'b0, "R9 reset idle", {62'd0, busy, done}, 64'd0);
    chk(mem_req_valid === 1'b0, "R10 reset no request", 64'(mem_req_valid), 64'd0);
    chk(fault === 2'd0 && phys_addr === '0, "R8 reset outputs", 64'(phys_addr), 64'd0);

    // R8: high canonical address, full rights, accessed already set
    va = 64'hFFFF_FFFF_8100_0000;
    build_chain(root, va, 64'h27, 64'h27, 64'h27, 64'h27);
    run_one(va, 2'd0, 2'd0, root, 1'b0);
    // R1: two badly sign-extended addresses
    run_one(64'h0001_0000_0000_1000, 2'd0, 2'd0, root, 1'b0);
    run_one(64'hFFFE_8000_0000_0000, 2'd0, 2'd0, root, 1'b0);
    // R4: every accessed flag clear, with ignored junk bits (R8)
    va = 64'h0000_7FFF_FFFF_F123;
    build_chain(root, va, 64'h07F0_0000_0000_0FC7, 64'h07, 64'h1F, 64'h07);
    run_one(va, 2'd1, 2'd3, root, 1'b0);
    // R3: invalid at the third level read
    build_chain(root, va, 64'h27, 64'h27, 64'h26, 64'h27);
    run_one(va, 2'd0, 2'd0, root, 1'b0);
    // R5: user bit clear at one level, user then supervisor
    build_chain(root, va, 64'h27, 64'h23, 64'h27, 64'h27);
    run_one(va, 2'd0, 2'd3, root, 1'b0);
    build_chain(root, va, 64'h27, 64'h23, 64'h27, 64'h27);
    run_one(va, 2'd0, 2'd2, root, 1'b0);
    // R6: write bit clear at the last level, write then read
    build_chain(root, va, 64'h27, 64'h27, 64'h27, 64'h25);
    run_one(va, 2'd1, 2'd0, root, 1'b0);
    build_chain(root, va, 64'h27, 64'h27, 64'h27, 64'h25);
    run_one(va, 2'd0, 2'd0, root, 1'b0);
    // R7: no-execute at the root level, fetch then read
    build_chain(root, va, 64'h8000_0000_0000_0027, 64'h27, 64'h27, 64'h27);
    run_one(va, 2'd2, 2'd0, root, 1'b0);
    build_chain(root, va, 64'h8000_0000_0000_0027, 64'h27, 64'h27, 64'h27);
    run_one(va, 2'd0, 2'd0, root, 1'b0);
    // R9: request presented during a walk is dropped
    build_chain(root, va, 64'h07, 64'h27, 64'h07, 64'h27);
    run_one(va, 2'd1, 2'd3, root, 1'b1);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] rr, vv;
      logic [1:0]  kk;
      rr = {12'd0, $urandom, 8'($urandom), 12'($urandom)};
      vv[47:0] = {$urandom, 16'($urandom)};
      vv[63:48] = {16{vv[47]}};
      if ($urandom % 8 == 0) vv[48 + ($urandom % 16)] ^= 1'b1;
      kk = 2'($urandom % 3);
      build_chain(rr, vv, rand_attr(), rand_attr(), rand_attr(), rand_attr());
      run_one(vv, kk, 2'($urandom), rr, (i % 10) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule